// File: doc/BRIEF.md
# APB Interrupt Register Bank

This block collects interrupt sources behind one APB3 slave port (16-bit address, 32-bit data, a 1 KiB window at offset 0). It has two groups.

The event group takes single-cycle trigger pulses. Each source latches into a sticky raw bit. Software clears a raw bit by writing a 1 to it. A software force bit per source lets debug code inject an interrupt without a real event. A per-source mask then gates the source, and the gated bits are ORed into `sys_irq`.

The level group takes live level inputs and gates each one with its own mask. It has no storage of its own, and the gated bits are ORed into `lvl_irq`. One level input may be tied to `sys_irq`, so the event group's summary can be merged into the level group.

Top module: `apb_irq_bank`

## Requirements
- R1: A 1 on `evt_in[i]` at a rising clock edge sets raw bit i. The raw bit then stays set until software clears it.
- R2: An APB write to offset 0x00 clears every raw bit whose write-data bit is 1. Raw bits written with 0 are left unchanged.
- R3: If a trigger pulse and a clearing write hit the same raw bit at the same edge, the bit ends up set.
- R4: Offset 0x04 is the force register. It reads back the last value written to it and resets to zero.
- R5: The event mask at offset 0x08 and the level mask at offset 0x10 both reset to all ones. In both masks, 1 disables a source and 0 enables it.
- R6: Reading offset 0x0C returns (raw OR force) AND NOT event-mask, per bit. `sys_irq` is 1 exactly when any of those bits is 1.
- R7: Reading offset 0x14 returns `lvl_in` AND NOT level-mask, per bit. `lvl_irq` is 1 exactly when any of those bits is 1. Both follow `lvl_in` in the same cycle.
- R8: Writes to offsets 0x0C and 0x14 change no register. Reads of any other offset, or of an address that is not word aligned, return zero. Bits above the group width read as zero.
- R9: `pready` is always 1 and `pslverr` is always 0, so every transfer finishes in its access phase.
- R10: When `sys_irq` is tied to a level input, a pending unmasked event raises `lvl_irq` in the same cycle, provided that level input is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 16 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| evt_in | input | N_EVT | Event trigger pulses |
| lvl_in | input | N_LVL | Level interrupt inputs |
| sys_irq | output | 1 | OR of the event-group status |
| lvl_irq | output | 1 | OR of the level-group status |

## Verification
The block holds three kinds of state: the raw latch, the force bits and the two masks. A wrong bit in any of them shows up in the first read of its own offset. If the bit is unmasked, it also shows up on `sys_irq` or `lvl_irq` in the same cycle. The bench therefore checks both interrupt outputs after every operation and compares every read against a model. A lost event, a clear that does not take effect, or a stray write to a status offset is then caught within one operation. The clear-versus-set collision is driven on purpose, because random traffic would rarely line up a trigger with a clearing write to the same bit.

// File: rtl/apb_irq_bank.sv
module apb_irq_bank #(
  parameter int N_EVT  = 4,
  parameter int N_LVL  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [N_EVT-1:0]  evt_in,
  input  logic [N_LVL-1:0]  lvl_in,
  output logic              sys_irq,
  output logic              lvl_irq
);
  localparam logic [7:0] OFF_RAW  = 8'h00;
  localparam logic [7:0] OFF_FRC  = 8'h01;
  localparam logic [7:0] OFF_EMSK = 8'h02;
  localparam logic [7:0] OFF_EST  = 8'h03;
  localparam logic [7:0] OFF_LMSK = 8'h04;
  localparam logic [7:0] OFF_LST  = 8'h05;

  logic [N_EVT-1:0] raw_q, frc_q, emsk_q, est;
  logic [N_LVL-1:0] lmsk_q, lst;
  logic             hit, wr, rd;
  logic [7:0]       word;
  logic             unused_bits;

  assign hit  = (paddr[ADDR_W-1:10] == '0) && (paddr[1:0] == 2'b00);
  assign word = paddr[9:2];
  assign wr   = psel && penable && pwrite && hit;
  assign rd   = psel && !pwrite && hit;
  assign unused_bits = ^pwdata;

  assign est     = (raw_q | frc_q) & ~emsk_q;
  assign lst     = lvl_in & ~lmsk_q;
  assign sys_irq = |est;
  assign lvl_irq = |lst;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      frc_q  <= '0;
      emsk_q <= '1;
      lmsk_q <= '1;
    end else begin
      if (wr && word == OFF_RAW) raw_q <= (raw_q & ~pwdata[N_EVT-1:0]) | evt_in;
      else                       raw_q <= raw_q | evt_in;
      if (wr && word == OFF_FRC)  frc_q  <= pwdata[N_EVT-1:0];
      if (wr && word == OFF_EMSK) emsk_q <= pwdata[N_EVT-1:0];
      if (wr && word == OFF_LMSK) lmsk_q <= pwdata[N_LVL-1:0];
    end
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      case (word)
        OFF_RAW:  prdata[N_EVT-1:0] = raw_q;
        OFF_FRC:  prdata[N_EVT-1:0] = frc_q;
        OFF_EMSK: prdata[N_EVT-1:0] = emsk_q;
        OFF_EST:  prdata[N_EVT-1:0] = est;
        OFF_LMSK: prdata[N_LVL-1:0] = lmsk_q;
        OFF_LST:  prdata[N_LVL-1:0] = lst;
        default:  prdata = '0;
      endcase
    end
  end

  assert_raw_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(evt_in)) == $past(evt_in)));

  assert_w1c_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == OFF_RAW) |=> ((raw_q & $past(pwdata[N_EVT-1:0] & ~evt_in)) == '0));

  assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (&emsk_q && &lmsk_q) |-> (!sys_irq && !lvl_irq));

  assert_status_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (word == OFF_EST || word == OFF_LST)) |=>
      ($stable(frc_q) && $stable(emsk_q) && $stable(lmsk_q)));

  assert_force_keeps_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && word != OFF_EST && word != OFF_LST) && sys_irq) |=> sys_irq);
endmodule

// File: tb/apb_irq_bank_bench.sv
module apb_irq_bank_bench;
  localparam int NE = 4;
  localparam int NL = 4;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr, sys_irq, lvl_irq;
  logic [NE-1:0] evt_in = '0;
  logic [NL-2:0] lvl_ext = '0;
  logic [NL-1:0] lvl_in;

  assign lvl_in = {sys_irq, lvl_ext};

  apb_irq_bank u_apb_irq_bank (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .evt_in(evt_in), .lvl_in(lvl_in),
    .sys_irq(sys_irq), .lvl_irq(lvl_irq));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [NE-1:0] raw_m = '0, frc_m = '0, emsk_m = '1;
  logic [NL-1:0] lmsk_m = '1;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [NE-1:0] est_m();
    return (raw_m | frc_m) & ~emsk_m;
  endfunction

  function automatic logic [NL-1:0] lst_m();
    logic [NL-1:0] l = {|est_m(), lvl_ext};
    return l & ~lmsk_m;
  endfunction

  function automatic logic [31:0] rd_m(input logic [15:0] a);
    if (a[1:0] != 0 || a[15:10] != 0) return 0;
    case (a[9:2])
      0: return 32'(raw_m);
      1: return 32'(frc_m);
      2: return 32'(emsk_m);
      3: return 32'(est_m());
      4: return 32'(lmsk_m);
      5: return 32'(lst_m());
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_irq(input string req);
    chk(req, {30'd0, sys_irq, lvl_irq}, {30'd0, |est_m(), |lst_m()});
  endtask

  task automatic apb_wr(input logic [15:0] a, input logic [31:0] d, input logic [NE-1:0] ev);
    @(negedge clk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk);
    penable = 1; evt_in = ev;
    #1 chk("R9", {30'd0, pready, pslverr}, 32'd2);
    @(posedge clk);
    if (a[1:0] == 0 && a[15:10] == 0)
      case (a[9:2])
        0: raw_m = (raw_m & ~d[NE-1:0]);
        1: frc_m = d[NE-1:0];
        2: emsk_m = d[NE-1:0];
        4: lmsk_m = d[NL-1:0];
        default: ;
      endcase
    raw_m = raw_m | ev;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; evt_in = '0;
  endtask

  task automatic apb_rd(input logic [15:0] a, input string req);
    @(negedge clk);
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk);
    penable = 1;
    #1 chk(req, prdata, rd_m(a));
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic pulse(input logic [NE-1:0] ev);
    @(negedge clk);
    evt_in = ev;
    @(posedge clk);
    raw_m = raw_m | ev;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R5 reset values, R4 force reset
    apb_rd(16'h0008, "R5");
    apb_rd(16'h0010, "R5");
    apb_rd(16'h0004, "R4");
    apb_rd(16'h0000, "R1");
    chk_irq("R5");
    // R1 event latches while masked
    pulse(4'b0101);
    apb_rd(16'h0000, "R1");
    chk_irq("R5");
    // R6 unmask, status and sys_irq
    apb_wr(16'h0008, 32'h0, '0);
    apb_rd(16'h000C, "R6");
    chk_irq("R6");
    // R10 cascade: unmask level bit 3
    apb_wr(16'h0010, 32'h7, '0);
    chk_irq("R10");
    apb_rd(16'h0014, "R10");
    // R2 partial clear, zeros unchanged
    apb_wr(16'h0000, 32'h1, '0);
    apb_rd(16'h0000, "R2");
    // R3 set wins
    apb_wr(16'h0000, 32'hF, 4'b0100);
    apb_rd(16'h0000, "R3");
    chk_irq("R3");
    apb_wr(16'h0000, 32'hF, '0);
    apb_rd(16'h0000, "R2");
    chk_irq("R2");
    // R4 force injects
    apb_wr(16'h0004, 32'hA, '0);
    apb_rd(16'h0004, "R4");
    apb_rd(16'h000C, "R6");
    chk_irq("R4");
    // R8 status writes ignored, unmapped reads zero
    apb_wr(16'h000C, 32'h0, '0);
    apb_wr(16'h0014, 32'hF, '0);
    apb_rd(16'h0004, "R8");
    apb_rd(16'h0008, "R8");
    apb_rd(16'h0010, "R8");
    chk_irq("R8");
    apb_rd(16'h0018, "R8");
    apb_rd(16'h0006, "R8");
    apb_rd(16'h0400, "R8");
    // R7 level group live
    @(negedge clk); lvl_ext = 3'b010;
    #1 chk_irq("R7");
    apb_rd(16'h0014, "R7");
    // random mix
    void'($urandom(32'd1234));
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 4);
      logic [15:0] a = 16'($urandom_range(0, 7) * 4);
      case (op)
        0: pulse(NE'($urandom));
        1: apb_wr(a, $urandom, NE'($urandom_range(0, 3) == 0 ? $urandom : 0));
        2: apb_rd(a, "R6");
        3: begin @(negedge clk); lvl_ext = (NL-1)'($urandom); end
        default: apb_rd(16'h0014, "R7");
      endcase
      #1 chk_irq("R7");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule